// File: doc/BRIEF.md
# Discriminator Line Test Pattern Generator

This block stands in for a pixel row's comparator outputs during bring-up of a zero-suppression stage. Once it has been started it produces one wide line word per clock cycle. Lines come in pairs: the first line of each pair is called line 0 and the second is called line 1. Each pair makes up one frame. The selected scenario fixes what each line contains. Some scenarios light the two outermost columns. One lights a cluster of columns around the 64-column block borders. Two of them move a single hit one column further along with each frame.

A start pulse does two things: it latches the scenario code and it clears the frame counter. The block then streams frames with a valid strobe until the scenario's frame budget is used up. After that it raises a done flag and keeps it high until the next start pulse. A code that selects no scenario produces no lines and completes at once. The row width and both frame budgets are parameters.

Top module: `dlt_pattern_gen`

## Requirements
- R1: While reset is asserted, and after reset until the first start, `frm_vld_o`=0, `done_o`=0, `line_idx_o`=0 and `line_o` is all zero.
- R2: A start pulse sampled at a clock edge makes line 0 of frame 0 appear right after that edge, with `frm_vld_o`=1. After that, `line_idx_o` alternates 0,1,0,1, one line per cycle.
- R3: Code 1 gives an all-zero line 0, and a line 1 with only bits 0 and LINE_W-1 set. Code 2 gives a line 0 with only bits 0 and LINE_W-1 set, and an all-zero line 1.
- R4: Code 3 gives a line 0 with exactly bits 0, 63, 64, 127 and 128 set, and an all-zero line 1.
- R5: Code 4 places a single hit in line 0 at column f for frame f, and keeps line 1 zero. Code 5 does the same in line 1 and keeps line 0 zero.
- R6: For codes 4 and 5 the hit column is f modulo LINE_W, so after column LINE_W-1 it returns to column 0.
- R7: Codes 1 to 3 emit FRAMES_FIXED frames, and codes 4 and 5 emit FRAMES_WALK frames. In the cycle after the last frame's line 1, `frm_vld_o`=0 and `done_o`=1.
- R8: `done_o` stays high until a start pulse. A start pulse, even one in the middle of a run, restarts the scenario it samples from frame 0.
- R9: Codes 0, 6 and 7 produce no valid line, and `done_o` goes high in the cycle after the start.
- R10: `line_o` is all zero whenever `frm_vld_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| test_sel_i | input | 3 | Scenario code, sampled with the start pulse |
| start_i | input | 1 | Single-cycle start or restart request |
| line_o | output | LINE_W | Emulated discriminator line |
| line_idx_o | output | 1 | 0 for the first line of a frame, 1 for the second |
| frm_vld_o | output | 1 | High while a line of a running scenario is presented |
| done_o | output | 1 | Frame budget reached or scenario code unused; held until the next start |

## Verification
The assertions assume that `start_i` is a one-cycle pulse that is synchronous to `clk`, and that `test_sel_i` is stable in the cycle where `start_i` is high. They also assume a start may arrive at any time, so each sequencing property is qualified by the absence of a start in its first cycle. The stimulus drives `start_i` and `test_sel_i` only on falling clock edges and holds start for exactly one cycle. It applies restarts both in the middle of a run and from the done state, so the sampled code is always settled.

// File: rtl/dlt_pkg.sv
package dlt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } run_st_e;

  localparam logic [2:0] TS_EDGE_L1  = 3'd1;
  localparam logic [2:0] TS_EDGE_L0  = 3'd2;
  localparam logic [2:0] TS_BLOCK_L0 = 3'd3;
  localparam logic [2:0] TS_WALK_L0  = 3'd4;
  localparam logic [2:0] TS_WALK_L1  = 3'd5;

  // Columns lit by the block-border scenario
  localparam int unsigned BLK_C0 = 0;
  localparam int unsigned BLK_C1 = 63;
  localparam int unsigned BLK_C2 = 64;
  localparam int unsigned BLK_C3 = 127;
  localparam int unsigned BLK_C4 = 128;

  function automatic logic sel_valid(input logic [2:0] s);
    return (s >= TS_EDGE_L1) && (s <= TS_WALK_L1);
  endfunction

  function automatic logic sel_walk(input logic [2:0] s);
    return (s == TS_WALK_L0) || (s == TS_WALK_L1);
  endfunction

endpackage

// File: rtl/dlt_rst_sync.sv
module dlt_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/dlt_seq_ctrl.sv
module dlt_seq_ctrl
  import dlt_pkg::*;
#(
  parameter  int unsigned LINE_W       = 960,
  parameter  int unsigned FRAMES_FIXED = 5000,
  parameter  int unsigned FRAMES_WALK  = 500,
  localparam int unsigned FRM_MAX      = (FRAMES_FIXED > FRAMES_WALK) ? FRAMES_FIXED : FRAMES_WALK,
  localparam int unsigned CNT_W        = $clog2(FRM_MAX + 1),
  localparam int unsigned POS_W        = $clog2(LINE_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [2:0]       sel_i,
  output logic             run_o,
  output logic             idx_o,
  output logic [2:0]       sel_o,
  output logic [POS_W-1:0] pos_o,
  output logic             done_o
);

  run_st_e          st_q, st_d;
  logic [2:0]       sel_q, sel_d;
  logic [CNT_W-1:0] frm_q, frm_d;
  logic             idx_q, idx_d;
  logic [POS_W-1:0] pos_q, pos_d;
  logic             en;
  logic [CNT_W-1:0] last_frm;
  logic             running;

  assign running  = (st_q == ST_RUN);
  assign last_frm = sel_walk(sel_q) ? CNT_W'(FRAMES_WALK - 1) : CNT_W'(FRAMES_FIXED - 1);
  assign en       = start_i | running;

  // Next-state logic
  always_comb begin
    st_d  = st_q;
    sel_d = sel_q;
    frm_d = frm_q;
    idx_d = idx_q;
    pos_d = pos_q;
    if (start_i) begin
      sel_d = sel_i;
      frm_d = '0;
      idx_d = 1'b0;
      pos_d = '0;
      st_d  = sel_valid(sel_i) ? ST_RUN : ST_DONE;
    end else if (running) begin
      if (!idx_q) begin
        idx_d = 1'b1;
      end else begin
        idx_d = 1'b0;
        if (frm_q == last_frm) begin
          st_d = ST_DONE;
        end else begin
          frm_d = frm_q + CNT_W'(1);
          pos_d = (pos_q == POS_W'(LINE_W - 1)) ? '0 : pos_q + POS_W'(1);
        end
      end
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      sel_q <= 3'd0;
      frm_q <= '0;
      idx_q <= 1'b0;
      pos_q <= '0;
    end else if (en) begin
      st_q  <= st_d;
      sel_q <= sel_d;
      frm_q <= frm_d;
      idx_q <= idx_d;
      pos_q <= pos_d;
    end
  end

  assign run_o  = running;
  assign idx_o  = idx_q;
  assign sel_o  = sel_q;
  assign pos_o  = pos_q;
  assign done_o = (st_q == ST_DONE);

  AST_IDX_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !idx_q && !start_i) |=> (running && idx_q)); // R2

  AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (pos_q <= POS_W'(LINE_W - 1))); // R6

  AST_FRM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (frm_q <= last_frm)); // R7

  AST_LAST_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (running && idx_q && (frm_q == last_frm) && !start_i) |=> (st_q == ST_DONE)); // R7

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_DONE) && !start_i) |=> (st_q == ST_DONE)); // R8

  AST_BAD_SEL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !sel_valid(sel_i)) |=> (st_q == ST_DONE)); // R9

endmodule

// File: rtl/dlt_walk_dec.sv
module dlt_walk_dec #(
  parameter  int unsigned LINE_W = 960,
  localparam int unsigned POS_W  = $clog2(LINE_W)
) (
  input  logic [POS_W-1:0]  pos_i,
  output logic [LINE_W-1:0] hot_o
);

  for (genvar b = 0; b < LINE_W; b++) begin : g_col
    assign hot_o[b] = (pos_i == POS_W'(b));
  end

endmodule

// File: rtl/dlt_line_build.sv
module dlt_line_build
  import dlt_pkg::*;
#(
  parameter int unsigned LINE_W = 960
) (
  input  logic              run_i,
  input  logic              idx_i,
  input  logic [2:0]        sel_i,
  input  logic [LINE_W-1:0] hot_i,
  output logic [LINE_W-1:0] line_o
);

  logic edge_on, blk_on, walk_on;

  // Per-line enables of the three pattern families
  always_comb begin
    edge_on = 1'b0;
    blk_on  = 1'b0;
    walk_on = 1'b0;
    if (run_i) begin
      unique case (sel_i)
        TS_EDGE_L1:  edge_on = idx_i;
        TS_EDGE_L0:  edge_on = !idx_i;
        TS_BLOCK_L0: blk_on  = !idx_i;
        TS_WALK_L0:  walk_on = !idx_i;
        TS_WALK_L1:  walk_on = idx_i;
        default:     ;
      endcase
    end
  end

  for (genvar b = 0; b < LINE_W; b++) begin : g_col
    localparam bit IS_EDGE = (b == 0) || (b == LINE_W - 1);
    localparam bit IS_BLK  = (b == BLK_C0) || (b == BLK_C1) || (b == BLK_C2) ||
                             (b == BLK_C3) || (b == BLK_C4);
    assign line_o[b] = (edge_on & IS_EDGE) | (blk_on & IS_BLK) | (walk_on & hot_i[b]);
  end

endmodule

// File: rtl/dlt_pattern_gen.sv
module dlt_pattern_gen
  import dlt_pkg::*;
#(
  parameter  int unsigned LINE_W       = 960,
  parameter  int unsigned FRAMES_FIXED = 5000,
  parameter  int unsigned FRAMES_WALK  = 500,
  localparam int unsigned POS_W        = $clog2(LINE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        test_sel_i,
  input  logic              start_i,
  output logic [LINE_W-1:0] line_o,
  output logic              line_idx_o,
  output logic              frm_vld_o,
  output logic              done_o
);

  logic             rst_n_s;
  logic             run;
  logic             idx;
  logic [2:0]       sel;
  logic [POS_W-1:0] pos;
  logic [LINE_W-1:0] hot;

  dlt_rst_sync i_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  dlt_seq_ctrl #(
    .LINE_W       (LINE_W),
    .FRAMES_FIXED (FRAMES_FIXED),
    .FRAMES_WALK  (FRAMES_WALK)
  ) i_seq_ctrl (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .start_i (start_i),
    .sel_i   (test_sel_i),
    .run_o   (run),
    .idx_o   (idx),
    .sel_o   (sel),
    .pos_o   (pos),
    .done_o  (done_o)
  );

  dlt_walk_dec #(
    .LINE_W (LINE_W)
  ) i_walk_dec (
    .pos_i (pos),
    .hot_o (hot)
  );

  dlt_line_build #(
    .LINE_W (LINE_W)
  ) i_line_build (
    .run_i  (run),
    .idx_i  (idx),
    .sel_i  (sel),
    .hot_i  (hot),
    .line_o (line_o)
  );

  assign frm_vld_o  = run;
  assign line_idx_o = run & idx;

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n_s)
    !frm_vld_o |-> (line_o == '0)); // R10

  AST_DONE_NO_VLD: assert property (@(posedge clk) disable iff (!rst_n_s)
    done_o |-> !frm_vld_o); // R7

  AST_WALK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (frm_vld_o && (((sel == TS_WALK_L0) && !line_idx_o) || ((sel == TS_WALK_L1) && line_idx_o)))
      |-> ($countones(line_o) == 1)); // R5

  AST_EDGE_PAIR: assert property (@(posedge clk) disable iff (!rst_n_s)
    (frm_vld_o && (((sel == TS_EDGE_L1) && line_idx_o) || ((sel == TS_EDGE_L0) && !line_idx_o)))
      |-> (line_o[0] && line_o[LINE_W-1] && ($countones(line_o) == 2))); // R3

endmodule

// File: tb/test_dlt_pattern_gen.sv
module test_dlt_pattern_gen;

  localparam int CLK_PERIOD = 10;
  localparam int WA = 960;
  localparam int WB = 16;

  typedef struct packed {
    logic [2:0]  sel;
    logic [15:0] frames;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{sel: 3'd1, frames: 16'd5000},
    '{sel: 3'd2, frames: 16'd5000},
    '{sel: 3'd3, frames: 16'd5000},
    '{sel: 3'd4, frames: 16'd500},
    '{sel: 3'd5, frames: 16'd500},
    '{sel: 3'd0, frames: 16'd0},
    '{sel: 3'd6, frames: 16'd0},
    '{sel: 3'd7, frames: 16'd0}
  };

  logic clk;
  logic rst_n;
  logic start_a, start_b;
  logic [2:0] sel_a, sel_b;
  logic [WA-1:0] line_a;
  logic [WB-1:0] line_b;
  logic idx_a, vld_a, done_a, idx_b, vld_b, done_b;

  int nvec = 0;
  int nerr = 0;

  dlt_pattern_gen i_dlt_pattern_gen (
    .clk (clk), .rst_n (rst_n), .test_sel_i (sel_a), .start_i (start_a),
    .line_o (line_a), .line_idx_o (idx_a), .frm_vld_o (vld_a), .done_o (done_a)
  );

  dlt_pattern_gen #(.LINE_W (WB), .FRAMES_FIXED (3), .FRAMES_WALK (40)) i_dlt_pattern_gen_small (
    .clk (clk), .rst_n (rst_n), .test_sel_i (sel_b), .start_i (start_b),
    .line_o (line_b), .line_idx_o (idx_b), .frm_vld_o (vld_b), .done_o (done_b)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [WA-1:0] exp_line(input logic [2:0] s, input int f, input bit ix, input int w);
    logic [WA-1:0] l;
    l = '0;
    case (s)
      3'd1: if (ix)  begin l[0] = 1'b1; l[w-1] = 1'b1; end
      3'd2: if (!ix) begin l[0] = 1'b1; l[w-1] = 1'b1; end
      3'd3: if (!ix) begin
              if (w > 0)   l[0]   = 1'b1;
              if (w > 63)  l[63]  = 1'b1;
              if (w > 64)  l[64]  = 1'b1;
              if (w > 127) l[127] = 1'b1;
              if (w > 128) l[128] = 1'b1;
            end
      3'd4: if (!ix) l[f % w] = 1'b1;
      3'd5: if (ix)  l[f % w] = 1'b1;
      default: ;
    endcase
    return l;
  endfunction

  function automatic int low_hit(input logic [WA-1:0] l);
    for (int k = 0; k < WA; k++) if (l[k]) return k;
    return -1;
  endfunction

  task automatic check(input string req, input bit inst, input bit ev, input bit ei, input bit ed,
                       input logic [WA-1:0] el);
    logic [WA-1:0] al;
    logic av, ai, ad;
    if (inst) begin al = {{(WA-WB){1'b0}}, line_b}; av = vld_b; ai = idx_b; ad = done_b; end
    else      begin al = line_a; av = vld_a; ai = idx_a; ad = done_a; end
    nvec++;
    if (av !== ev || ai !== ei || ad !== ed || al !== el) begin
      nerr++;
      $display("FAIL %s: actual vld=%b idx=%b done=%b hits=%0d low=%0d, expected vld=%b idx=%b done=%b hits=%0d low=%0d",
               req, av, ai, ad, $countones(al), low_hit(al), ev, ei, ed, $countones(el), low_hit(el));
    end
  endtask

  task automatic pulse(input bit inst, input logic [2:0] s);
    @(negedge clk);
    if (inst) begin start_b = 1'b1; sel_b = s; end
    else      begin start_a = 1'b1; sel_a = s; end
    @(negedge clk);
    start_a = 1'b0;
    start_b = 1'b0;
  endtask

  function automatic string req_of(input logic [2:0] s);
    case (s)
      3'd1, 3'd2: return "R3";
      3'd3:       return "R4";
      3'd4, 3'd5: return "R5";
      default:    return "R9";
    endcase
  endfunction

  task automatic run_test(input bit inst, input logic [2:0] s, input int frames, input int w);
    pulse(inst, s);
    for (int f = 0; f < frames; f++) begin
      for (int ix = 0; ix < 2; ix++) begin
        check({req_of(s), "/R2"}, inst, 1'b1, ix[0], 1'b0, exp_line(s, f, ix[0], w));
        @(negedge clk);
      end
    end
    check({req_of(s), "/R7 end"}, inst, 1'b0, 1'b0, 1'b1, '0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual run still going, expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    rst_n   = 1'b0;
    start_a = 1'b0;
    start_b = 1'b0;
    sel_a   = 3'd0;
    sel_b   = 3'd0;
    repeat (3) @(negedge clk);
    check("R1 in reset", 1'b0, 1'b0, 1'b0, 1'b0, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after reset", 1'b0, 1'b0, 1'b0, 1'b0, '0);
    check("R1 after reset small", 1'b1, 1'b0, 1'b0, 1'b0, '0);

    // Table of scenarios on the full-width instance
    foreach (VECS[n]) begin
      run_test(1'b0, VECS[n].sel, int'(VECS[n].frames), WA);
    end

    // R8: done held without start, R10 zero line meanwhile
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R8/R10 done hold", 1'b0, 1'b0, 1'b0, 1'b1, '0);
    end

    // R6: walking hit wraps on the narrow instance
    run_test(1'b1, 3'd4, 40, WB);
    run_test(1'b1, 3'd5, 40, WB);

    // R8: restart in the middle of a run
    pulse(1'b1, 3'd4);
    for (int k = 0; k < 7; k++) @(negedge clk);
    check("R8 mid-run before restart", 1'b1, 1'b1, 1'b1, 1'b0, exp_line(3'd4, 3, 1'b1, WB));
    run_test(1'b1, 3'd1, 3, WB);
    run_test(1'b1, 3'd3, 3, WB);

    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule